// File: doc/BRIEF.md
# Fractional-Rate Frame Valid Tagger

This block sits between a converter's sample output and one slot of a serial frame. The frame rate may be higher than the sample rate, and the ratio between them need not be a whole number. On every frame strobe the block decides whether this frame carries a new sample. It then builds a 16-bit slot word. The top bit of that word is a data-valid flag, and the low bits carry the most recent sample in one of two layouts: linear, or companded (an 8-bit code). On frames that carry a new sample it also pulses a sample-taken strobe, so that the upstream source can move on to its next sample.

The spacing of fresh frames follows a ratio I + N/D. The three values are programmed in a minus-one encoding: the register fields hold I-1, N and D-1. Each fresh frame opens an interval of I frames. A modulo-D accumulator collects N on every fresh frame. When it wraps, that interval is one frame longer. A bypass input marks every frame fresh, for the case where the frame rate equals the sample rate. The divider fields and N are only changed while reset is asserted, and the configuration keeps N below D.

Top module: `frame_valid_tagger`

## Requirements
- R1: After reset, slot_word is 0 and sample_take is 0. The first frame strobe after reset is a fresh frame.
- R2: slot_word bit 15 is the data-valid flag. With flag_en high, it is 1 for a fresh frame and 0 for a filler frame.
- R3: With companded low (linear layout), slot_word bits 14:0 equal sample_in[14:0] as captured at the frame strobe.
- R4: With companded high, slot_word bits 14:8 are 0 and bits 7:0 equal sample_in[7:0] as captured at the frame strobe.
- R5: The interval is I = i_m1 + 1. With n_val = 0, exactly one frame in every I frames is fresh, starting with the first frame.
- R6: After each fresh frame, n_val is added to an accumulator taken modulo D = d_m1 + 1. When the sum reaches D or more, D is subtracted and that interval grows to I + 1 frames. For example, with i_m1 = 3, n_val = 4 and d_m1 = 8, exactly 9 of every 40 frames are fresh, with gaps of 4 or 5 frames.
- R7: When d_m1 = 0, n_val is ignored and the interval is exactly I frames.
- R8: While div_bypass is high, every frame is fresh, and the countdown and accumulator hold their values. When bypass is released, the spacing resumes from the held state.
- R9: With flag_en low, bit 15 is 0 on every frame. The low bits still carry the current sample, and sample_take still follows the fresh-frame schedule.
- R10: sample_take is a one-cycle pulse. It appears in the cycle after a strobe of a fresh frame, in the same cycle that slot_word updates, and never in any other cycle.
- R11: In a cycle that follows no frame strobe, slot_word holds its value and sample_take is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| frame_stb | input | 1 | One-cycle frame strobe |
| sample_in | input | 15 | Latest converter sample (linear value, or 8-bit code in bits 7:0) |
| companded | input | 1 | 0 = linear layout, 1 = companded layout |
| flag_en | input | 1 | Enables the data-valid flag in bit 15 |
| div_bypass | input | 1 | Marks every frame fresh and freezes the divider |
| i_m1 | input | CNT_W | Integer ratio minus one |
| n_val | input | FRAC_W | Fractional numerator N |
| d_m1 | input | FRAC_W | Fractional denominator minus one |
| slot_word | output | 16 | Slot word: flag in bit 15, payload below it |
| sample_take | output | 1 | Pulse marking a consumed sample |

## Verification
The bench builds the block with its default widths, CNT_W = 6 and FRAC_W = 6. These widths allow ratios of up to 64 whole frames and denominators of up to 64, so the 8:1 integer case, the 4 + 4/9 case, and a D = 1 case with a nonzero N all fit. A reference model of the countdown and accumulator predicts the flag and the take pulse for every frame. Irregular idle gaps between strobes also exercise the hold behaviour. Bypass is toggled in the middle of a schedule, to show that the spacing resumes where it stopped.

// File: rtl/fvt_pkg.sv
`timescale 1ns/1ps
package fvt_pkg;
  localparam int WORD_W   = 16;
  localparam int SAMPLE_W = WORD_W - 1;
  localparam int PCM_W    = 8;
  localparam int FLAG_BIT = WORD_W - 1;

  typedef enum logic {
    LAYOUT_LINEAR  = 1'b0,
    LAYOUT_COMPAND = 1'b1
  } layout_e;
endpackage

// File: rtl/fvt_pace.sv
`timescale 1ns/1ps
module fvt_pace #(
  parameter int CNT_W  = 6,
  parameter int FRAC_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_stb,
  input  logic              bypass,
  input  logic [CNT_W-1:0]  i_m1,
  input  logic [FRAC_W-1:0] n_val,
  input  logic [FRAC_W-1:0] d_m1,
  output logic              fresh
);
  localparam int CW = CNT_W + 1;
  localparam int SW = FRAC_W + 1;

  logic [CW-1:0]     cnt_q, cnt_n;
  logic [FRAC_W-1:0] acc_q, acc_n;
  logic [SW-1:0]     sum, dval, diff;
  logic              carry;

  always_comb begin
    fresh = bypass || (cnt_q == '0);
    sum   = {1'b0, acc_q} + {1'b0, n_val};
    dval  = {1'b0, d_m1} + SW'(1);
    diff  = sum - dval;
    carry = 1'b0;
    acc_n = acc_q;
    cnt_n = cnt_q;
    if (frame_stb && !bypass) begin
      if (cnt_q == '0) begin
        if (d_m1 == '0) begin
          acc_n = '0;
        end else if (sum >= dval) begin
          carry = 1'b1;
          acc_n = diff[FRAC_W-1:0];
        end else begin
          acc_n = sum[FRAC_W-1:0];
        end
        cnt_n = {1'b0, i_m1} + CW'(carry);
      end else begin
        cnt_n = cnt_q - CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else if (frame_stb) begin
      cnt_q <= cnt_n;
      acc_q <= acc_n;
    end
  end

  // Accumulator remains a residue modulo D under a fixed configuration
  p_acc_below_d_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (d_m1 != '0) |-> (acc_q <= d_m1));

  // Integer-only mode leaves the accumulator at zero after a fresh frame
  p_d1_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_stb && !bypass && cnt_q == '0 && d_m1 == '0) |=> (acc_q == '0));

  // Bypass freezes the divider state
  p_bypass_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(bypass)) |-> ($stable(cnt_q) && $stable(acc_q)));
endmodule

// File: rtl/fvt_pack.sv
`timescale 1ns/1ps
module fvt_pack
  import fvt_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic                fresh,
  input  logic                flag_en,
  input  logic                companded,
  input  logic [SAMPLE_W-1:0] sample,
  output logic [WORD_W-1:0]   word_q,
  output logic                take_q
);
  logic [WORD_W-1:0]   word_n;
  logic                take_n;
  logic [SAMPLE_W-1:0] payload;
  layout_e             layout;

  always_comb begin
    layout  = layout_e'(companded);
    payload = (layout == LAYOUT_COMPAND)
              ? {{(SAMPLE_W-PCM_W){1'b0}}, sample[PCM_W-1:0]}
              : sample;
    word_n  = word_q;
    take_n  = 1'b0;
    if (load) begin
      word_n = {flag_en && fresh, payload};
      take_n = fresh;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      take_q <= 1'b0;
    end else begin
      word_q <= word_n;
      take_q <= take_n;
    end
  end

  p_comp_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(load && companded)) |-> (word_q[SAMPLE_W-1:PCM_W] == '0));

  p_flag_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(load && !flag_en)) |-> !word_q[FLAG_BIT]);
endmodule

// File: rtl/frame_valid_tagger.sv
`timescale 1ns/1ps
module frame_valid_tagger
  import fvt_pkg::*;
#(
  parameter int CNT_W  = 6,
  parameter int FRAC_W = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_stb,
  input  logic [SAMPLE_W-1:0] sample_in,
  input  logic                companded,
  input  logic                flag_en,
  input  logic                div_bypass,
  input  logic [CNT_W-1:0]    i_m1,
  input  logic [FRAC_W-1:0]   n_val,
  input  logic [FRAC_W-1:0]   d_m1,
  output logic [WORD_W-1:0]   slot_word,
  output logic                sample_take
);
  logic fresh;

  fvt_pace #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_pace (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_stb (frame_stb),
    .bypass    (div_bypass),
    .i_m1      (i_m1),
    .n_val     (n_val),
    .d_m1      (d_m1),
    .fresh     (fresh)
  );

  fvt_pack u_pack (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (frame_stb),
    .fresh     (fresh),
    .flag_en   (flag_en),
    .companded (companded),
    .sample    (sample_in),
    .word_q    (slot_word),
    .take_q    (sample_take)
  );

  p_take_after_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sample_take |-> $past(frame_stb));

  p_flag_needs_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(frame_stb) && slot_word[FLAG_BIT]) |-> sample_take);

  p_bypass_every_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(frame_stb && div_bypass)) |-> sample_take);

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(frame_stb)) |-> ($stable(slot_word) && !sample_take));
endmodule

// File: tb/frame_valid_tagger_test.sv
`timescale 1ns/1ps
module frame_valid_tagger_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_stb = 1'b0;
  logic [14:0] sample_in = '0;
  logic        companded = 1'b0;
  logic        flag_en = 1'b1;
  logic        div_bypass = 1'b0;
  logic [5:0]  i_m1 = '0;
  logic [5:0]  n_val = '0;
  logic [5:0]  d_m1 = '0;
  logic [15:0] slot_word;
  logic        sample_take;

  int vectors = 0;
  int fails = 0;
  int takes = 0;
  int m_cnt = 0;
  int m_acc = 0;
  bit done = 1'b0;
  logic [15:0] last_word = '0;
  logic mon_hit;

  logic [15:0] q_word[$];
  logic        q_take[$];
  string       q_tag[$];

  always #5 clk = ~clk;

  frame_valid_tagger uut (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .sample_in(sample_in),
    .companded(companded), .flag_en(flag_en), .div_bypass(div_bypass),
    .i_m1(i_m1), .n_val(n_val), .d_m1(d_m1),
    .slot_word(slot_word), .sample_take(sample_take)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    m_cnt = 0;
    m_acc = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic send_frame(input logic [14:0] s, input string tag, input int gap);
    bit v;
    bit car;
    logic [14:0] pay;
    @(negedge clk);
    frame_stb = 1'b1;
    sample_in = s;
    if (div_bypass) v = 1'b1;
    else begin
      v = (m_cnt == 0);
      if (v) begin
        car = 1'b0;
        if (d_m1 != 0) begin
          m_acc += int'(n_val);
          if (m_acc >= int'(d_m1) + 1) begin
            m_acc -= int'(d_m1) + 1;
            car = 1'b1;
          end
        end else m_acc = 0;
        m_cnt = int'(i_m1) + int'(car);
      end else m_cnt--;
    end
    pay = companded ? {7'b0, s[7:0]} : s;
    q_word.push_back({flag_en && v, pay});
    q_take.push_back(v);
    q_tag.push_back(tag);
    @(negedge clk);
    frame_stb = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  // Monitor: compares each frame result and idle-cycle behaviour (R11)
  always @(posedge clk) begin
    mon_hit = frame_stb && rst_n;
    #2;
    if (!rst_n) last_word = slot_word;
    else if (mon_hit) begin
      if (q_word.size() == 0) begin
        vectors++; fails++;
        $display("FAIL R10: actual unexpected result expected empty queue");
      end else begin
        string t;
        logic [15:0] ew;
        logic et;
        t = q_tag.pop_front(); ew = q_word.pop_front(); et = q_take.pop_front();
        chk({t, " word"}, slot_word, ew);
        chk({t, " take R10"}, {15'b0, sample_take}, {15'b0, et});
      end
      if (sample_take) takes++;
      last_word = slot_word;
    end else begin
      chk("R11 idle take", {15'b0, sample_take}, 16'h0);
      chk("R11 idle hold", slot_word, last_word);
    end
  end

  initial begin
    int t0;
    do_reset();
    @(negedge clk);
    chk("R1 reset word", slot_word, 16'h0);
    chk("R1 reset take", {15'b0, sample_take}, 16'h0);

    // R5/R1/R2/R3: integer ratio 8, linear
    i_m1 = 6'd7; n_val = 6'd0; d_m1 = 6'd0;
    do_reset();
    t0 = takes;
    for (int k = 0; k < 24; k++) send_frame(15'(16'h4a31 + k * 613), "R5 R2 R3 int8", k % 3);
    repeat (2) @(negedge clk);
    chk("R5 fresh count in 24", 16'(takes - t0), 16'd3);

    // R6: 4 + 4/9
    i_m1 = 6'd3; n_val = 6'd4; d_m1 = 6'd8;
    do_reset();
    t0 = takes;
    for (int k = 0; k < 40; k++) send_frame(15'(k * 1117 + 5), "R6 frac", (k % 4 == 1) ? 2 : 0);
    repeat (2) @(negedge clk);
    chk("R6 fresh count in 40", 16'(takes - t0), 16'd9);

    // R4: companded layout, same schedule continues
    companded = 1'b1;
    for (int k = 0; k < 12; k++) send_frame(15'h7f00 | 15'(k * 29 + 200), "R4 compand", 1);
    companded = 1'b0;

    // R9: flag disabled
    flag_en = 1'b0;
    for (int k = 0; k < 12; k++) send_frame(15'h6000 + 15'(k * 77), "R9 noflag", k % 2);
    flag_en = 1'b1;

    // R8: bypass mid-schedule, then resume
    div_bypass = 1'b1;
    for (int k = 0; k < 8; k++) send_frame(15'(k * 4099), "R8 bypass", 0);
    div_bypass = 1'b0;
    for (int k = 0; k < 12; k++) send_frame(15'(k * 3 + 9), "R8 resume", 1);

    // R7: D = 1 ignores N
    i_m1 = 6'd2; n_val = 6'd5; d_m1 = 6'd0;
    do_reset();
    t0 = takes;
    for (int k = 0; k < 12; k++) send_frame(15'(k + 300), "R7 d1", 0);
    repeat (2) @(negedge clk);
    chk("R7 fresh count in 12", 16'(takes - t0), 16'd4);

    repeat (4) @(negedge clk);
    chk("R10 queue drained", 16'(q_word.size()), 16'd0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      vectors++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule